// File: doc/BRIEF.md
# FIFO-Driven I2C Bus Master

This block is a single-master I2C engine controlled by a 13-bit command/data word and observed through an 11-bit status word. Its data lives in one byte queue that both directions share. The host loads bytes into the queue and then starts a write. The write sends every queued byte, MSB first, between one START and one STOP condition. The host can start a read instead. A read pops the head of the queue and sends it as the address byte, then clocks in a preset number of bytes and appends them to the same queue. Each host access is answered with a one-cycle acknowledge pulse. For a write or read command, that pulse is held back until the bus transaction has finished.

The bus pins are open-drain. The block provides active-high pull-down enables for SCL and SDA, and the pad drives a line low only while its enable is 1. The block reads the resolved SDA level. A programmable divider splits each bit period into four quarters of `QUARTER` system clocks. `QUARTER` must be at least 2. There is no clock stretching, no arbitration and no 10-bit addressing.

Top module: `i2c_fifo_master`

## Requirements
- R1: After reset the queue is empty, the NACK flag is 0, both pull-down enables are 0, and the status word reads 0x100.
- R2: A write with bit 9 set appends bits 7:0 to the queue. The queue holds `DEPTH` bytes. Status bit 9 is 1 when the queue is full, and an append while full is ignored.
- R3: A write with bit 8 set empties the queue. If bit 9 is set in the same word, that append is ignored.
- R4: While `hostRd` is high, the status word is {NACK flag (bit 10), full (bit 9), empty (bit 8), head byte (bits 7:0)}. The head field is 0x00 when the queue is empty. Each accepted read pops one byte, and a read of an empty queue changes nothing.
- R5: A write without bit 10 or bit 11 set, and every read, is answered by `hostAck` high for exactly the cycle after the access. A write with bit 10 or bit 11 set is answered by a pulse only after its STOP condition. Host accesses made while a transaction runs are ignored and get no acknowledge.
- R6: A write with bit 10 set runs a START condition, sends every queued byte in queue order with MSB first (each followed by an acknowledge slot), then runs a STOP condition. The queue is empty afterwards. If the queue is empty when the command starts, only START and STOP are produced.
- R7: If a byte sent by the master is not acknowledged, the master sends no further bytes, goes to STOP and sets the NACK flag. Bytes not yet sent remain in the queue.
- R8: A write with bit 12 set loads bits 7:0 as the read count. A write with bit 11 set (and bit 10 clear) pops the head byte and sends it as the address, then receives that many bytes MSB first and appends them to the queue.
- R9: During a read the master acknowledges (SDA low) every received byte except the last, which it leaves unacknowledged. A read count of 0 ends with STOP right after the address.
- R10: If the address byte of a read is not acknowledged, no bytes are received and the NACK flag is set.
- R11: The NACK flag is cleared when each write or read command starts.
- R12: SDA changes while SCL is released only for START (falling) and STOP (rising). During a transaction, consecutive SCL rising edges are 4×`QUARTER` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostRd | input | 1 | Host read strobe; pops the head byte |
| hostWr | input | 1 | Host write strobe |
| hostWrData | input | 13 | Command strobes in bits 12:8, data byte in bits 7:0 |
| hostRdData | output | 11 | Status word {nack, full, empty, head} |
| hostAck | output | 1 | One-cycle acknowledge of a host access |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| sdaIn | input | 1 | Resolved level of the SDA line |

## Verification
The bench builds the block with `DEPTH` = 4 and `QUARTER` = 3. The shallow queue makes the full flag and the dropped append reachable with only five writes. The short quarter keeps every bus transaction to a few hundred cycles while still leaving one cycle of margin between SCL rising and the SDA sample. An attached bus-device model acknowledges or refuses chosen bytes and supplies read data. This lets the refusal, read-count and master-acknowledge cases all run against the same queue.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  // Strobes issued by the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic clear;      // empty the queue
    logic hostPush;   // append host byte
    logic rxPush;     // append received byte
    logic pop;        // drop head byte
    logic loadShift;  // copy head into shift register
    logic shift;      // shift left by one
    logic shiftBit;   // bit inserted on shift
    logic setCount;   // load read count from host byte
    logic loadRemain; // start read countdown
    logic decRemain;  // one byte received
    logic setNack;    // refusal seen
    logic clrNack;    // new command started
  } ctrlStrobes_t;

endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  logic [7:0]   wrByte,
  output logic [7:0]   head,
  output logic         fifoEmpty,
  output logic         fifoFull,
  output logic         shiftMsb,
  output logic         remainZero,
  output logic         remainOne,
  output logic         nack
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [7:0]       shiftReg;
  logic [7:0]       rxCount;
  logic [7:0]       remain;
  logic             doPop, doPush, pushReq;
  logic [7:0]       pushData;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign pushReq   = strb.hostPush | strb.rxPush;
  assign doPop     = strb.pop & ~fifoEmpty & ~strb.clear;
  assign doPush    = pushReq & ~strb.clear & (~fifoFull | doPop);
  assign pushData  = strb.rxPush ? shiftReg : wrByte;
  assign head      = fifoEmpty ? 8'h00 : mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  // Shift register, read counters and refusal flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxCount  <= '0;
      remain   <= '0;
      nack     <= 1'b0;
    end else begin
      if (strb.loadShift)  shiftReg <= head;
      else if (strb.shift) shiftReg <= {shiftReg[6:0], strb.shiftBit};
      if (strb.setCount)   rxCount <= wrByte;
      if (strb.loadRemain) remain <= strb.setCount ? wrByte : rxCount;
      else if (strb.decRemain && remain != '0) remain <= remain - 8'd1;
      if (strb.clrNack)      nack <= 1'b0;
      else if (strb.setNack) nack <= 1'b1;
    end
  end

  assign shiftMsb   = shiftReg[7];
  assign remainZero = (remain == 8'd0);
  assign remainOne  = (remain == 8'd1);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  a_r2_full_push_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && strb.hostPush && !strb.pop && !strb.clear) |=> (count == $past(count)));

  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> fifoEmpty);

  a_r4_pop_removes_one: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !fifoEmpty && !strb.clear && !pushReq) |=> (count == $past(count) - CNT_W'(1)));

  a_r11_nack_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrNack && !strb.setNack) |=> !nack);

endmodule

// File: rtl/i2cm_control.sv
module i2cm_control
  import i2cm_pkg::*;
#(
  parameter int QUARTER = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostRd,
  input  logic         hostWr,
  input  logic [4:0]   cmdBits,
  input  logic         sdaIn,
  input  logic         fifoEmpty,
  input  logic         shiftMsb,
  input  logic         remainZero,
  input  logic         remainOne,
  output ctrlStrobes_t strb,
  output logic         hostAck,
  output logic         sclOe,
  output logic         sdaOe
);
  localparam int DIV_W = (QUARTER > 1) ? $clog2(QUARTER) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_TXB, S_RXB, S_STOP} state_t;

  state_t           state, stateNxt;
  logic [DIV_W-1:0] divCnt;
  logic [1:0]       q;
  logic [3:0]       bitIdx, bitIdxNxt;
  logic             rxMode, rxModeNxt;
  logic             ackSeen, ackNxt, sdaDrive;
  logic             busy, tick, sampleTick, slotEnd;

  wire cmdClear = cmdBits[0];
  wire cmdPush  = cmdBits[1];
  wire cmdTx    = cmdBits[2];
  wire cmdRx    = cmdBits[3];
  wire cmdCount = cmdBits[4];

  assign busy       = (state != S_IDLE);
  assign tick       = busy && (divCnt == DIV_W'(QUARTER - 1));
  assign sampleTick = tick && (q == 2'd2);
  assign slotEnd    = tick && (q == 2'd3);

  // Quarter-bit timebase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      q      <= '0;
    end else if (!busy) begin
      divCnt <= '0;
      q      <= '0;
    end else if (tick) begin
      divCnt <= '0;
      q      <= q + 2'd1;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // Sequencer
  always_comb begin
    strb      = '0;
    stateNxt  = state;
    bitIdxNxt = bitIdx;
    rxModeNxt = rxMode;
    ackNxt    = 1'b0;
    sdaDrive  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (hostWr) begin
          strb.clear    = cmdClear;
          strb.hostPush = cmdPush & ~cmdClear;
          strb.setCount = cmdCount;
          if (cmdTx || cmdRx) begin
            stateNxt        = S_START;
            rxModeNxt       = ~cmdTx;
            strb.clrNack    = 1'b1;
            strb.loadRemain = 1'b1;
          end else begin
            ackNxt = 1'b1;
          end
        end else if (hostRd) begin
          strb.pop = 1'b1;
          ackNxt   = 1'b1;
        end
      end
      S_START: begin
        if (slotEnd) begin
          if (fifoEmpty) begin
            stateNxt = S_STOP;
          end else begin
            strb.loadShift = 1'b1;
            strb.pop       = 1'b1;
            bitIdxNxt      = '0;
            stateNxt       = S_TXB;
          end
        end
      end
      S_TXB: begin
        sdaDrive = (bitIdx < 4'd8) ? ~shiftMsb : 1'b0;
        if (slotEnd) begin
          if (bitIdx < 4'd8) begin
            strb.shift = 1'b1;
            bitIdxNxt  = bitIdx + 4'd1;
          end else if (!ackSeen) begin
            strb.setNack = 1'b1;
            stateNxt     = S_STOP;
          end else if (rxMode) begin
            bitIdxNxt = '0;
            stateNxt  = remainZero ? S_STOP : S_RXB;
          end else if (fifoEmpty) begin
            stateNxt = S_STOP;
          end else begin
            strb.loadShift = 1'b1;
            strb.pop       = 1'b1;
            bitIdxNxt      = '0;
          end
        end
      end
      S_RXB: begin
        sdaDrive = (bitIdx == 4'd8) && !remainOne;
        if (sampleTick && bitIdx < 4'd8) begin
          strb.shift    = 1'b1;
          strb.shiftBit = sdaIn;
        end
        if (slotEnd) begin
          if (bitIdx < 4'd8) begin
            bitIdxNxt = bitIdx + 4'd1;
          end else begin
            strb.rxPush    = 1'b1;
            strb.decRemain = 1'b1;
            bitIdxNxt      = '0;
            if (remainOne) stateNxt = S_STOP;
          end
        end
      end
      S_STOP: begin
        if (slotEnd) begin
          stateNxt = S_IDLE;
          ackNxt   = 1'b1;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitIdx  <= '0;
      rxMode  <= 1'b0;
      ackSeen <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      state   <= stateNxt;
      bitIdx  <= bitIdxNxt;
      rxMode  <= rxModeNxt;
      hostAck <= ackNxt;
      if (sampleTick && state == S_TXB && bitIdx == 4'd8) ackSeen <= ~sdaIn;
    end
  end

  // Open-drain pin enables, registered from the bit phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          sclOe <= 1'b0;
          sdaOe <= 1'b0;
        end
        S_START: begin
          sclOe <= 1'b0;
          sdaOe <= q[1];
        end
        S_TXB, S_RXB: begin
          sclOe <= ~q[1];
          if (q == 2'd1) sdaOe <= sdaDrive;
        end
        S_STOP: begin
          sclOe <= ~q[1];
          if (q != 2'd0) sdaOe <= (q != 2'd3);
        end
        default: begin
          sclOe <= 1'b0;
          sdaOe <= 1'b0;
        end
      endcase
    end
  end

  a_r5_ack_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);

  a_r5_ack_only_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> (state == S_IDLE));

  a_r7_refusal_goes_stop: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TXB && slotEnd && bitIdx == 4'd8 && !ackSeen) |=> (state == S_STOP));

  a_r9_master_ack_policy: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RXB && bitIdx == 4'd8 && q == 2'd2) |-> (sdaOe == !remainOne));

  a_r12_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_TXB || state == S_RXB) && !sclOe && !$past(sclOe)) |-> $stable(sdaOe));

endmodule

// File: rtl/i2c_fifo_master.sv
module i2c_fifo_master
  import i2cm_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int QUARTER = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic [12:0] hostWrData,
  output logic [10:0] hostRdData,
  output logic        hostAck,
  output logic        sclOe,
  output logic        sdaOe,
  input  logic        sdaIn
);
  ctrlStrobes_t strb;
  logic [7:0]   head;
  logic         fifoEmpty, fifoFull, shiftMsb, remainZero, remainOne, nack;

  i2cm_control #(.QUARTER(QUARTER)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .hostRd     (hostRd),
    .hostWr     (hostWr),
    .cmdBits    (hostWrData[12:8]),
    .sdaIn      (sdaIn),
    .fifoEmpty  (fifoEmpty),
    .shiftMsb   (shiftMsb),
    .remainZero (remainZero),
    .remainOne  (remainOne),
    .strb       (strb),
    .hostAck    (hostAck),
    .sclOe      (sclOe),
    .sdaOe      (sdaOe)
  );

  i2cm_datapath #(.DEPTH(DEPTH)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrByte     (hostWrData[7:0]),
    .head       (head),
    .fifoEmpty  (fifoEmpty),
    .fifoFull   (fifoFull),
    .shiftMsb   (shiftMsb),
    .remainZero (remainZero),
    .remainOne  (remainOne),
    .nack       (nack)
  );

  assign hostRdData = {nack, fifoFull, fifoEmpty, head};

endmodule

// File: tb/i2c_fifo_master_tb.sv
`timescale 1ns / 1ps
module i2c_fifo_master_tb;
  localparam int DEPTH   = 4;
  localparam int QUARTER = 3;
  localparam time CLK_P  = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostRd = 1'b0;
  logic        hostWr = 1'b0;
  logic [12:0] hostWrData = '0;
  logic [10:0] hostRdData;
  logic        hostAck, sclOe, sdaOe;
  logic        slvLow = 1'b0;

  wire sclLine = ~sclOe;
  wire sdaLine = ~(sdaOe | slvLow);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  i2c_fifo_master #(.DEPTH(DEPTH), .QUARTER(QUARTER)) u_dut (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .hostAck(hostAck),
    .sclOe(sclOe), .sdaOe(sdaOe), .sdaIn(sdaLine)
  );

  always #(CLK_P / 2.0) clk = ~clk;

  // ---------------- bus device model ----------------
  int   bitCnt = 0, byteCnt = 0, nackAt = -1;
  bit   inTx = 0, readMode = 0, masterNacked = 0;
  logic [7:0] sh = '0;
  logic [7:0] logB [16];
  bit   mAck [16];
  int   logN = 0, mAckN = 0, starts = 0, stops = 0;
  time  lastRise = 0;
  bit   firstRise = 1;
  int   badPeriod = 0, periods = 0;

  function automatic logic [7:0] rdByte(input int k);
    return 8'h96 + 8'(37 * k);
  endfunction

  always @(negedge sdaLine) if (sclLine === 1'b1) begin
    starts++; inTx = 1; bitCnt = 0; byteCnt = 0; readMode = 0; masterNacked = 0; firstRise = 1;
  end

  always @(posedge sdaLine) if (sclLine === 1'b1 && inTx) begin
    stops++; inTx = 0;
  end

  always @(posedge sclLine) if (inTx) begin
    if (!firstRise) begin
      periods++;
      if ($time - lastRise != 4 * QUARTER * CLK_P) badPeriod++;
    end
    firstRise = 0; lastRise = $time;
    if (bitCnt < 8) sh = {sh[6:0], sdaLine};
    else if (bitCnt == 8 && readMode && byteCnt > 0) begin
      mAck[mAckN] = ~sdaLine; mAckN++;
      if (sdaLine) masterNacked = 1;
    end
    bitCnt++;
  end

  always @(negedge sclLine) if (inTx) begin
    logic [7:0] tb;
    if (bitCnt >= 1 && bitCnt <= 7 && readMode && byteCnt > 0) begin
      tb = rdByte(byteCnt - 1);
      slvLow = ~tb[7 - bitCnt];
    end else if (bitCnt == 8) begin
      if (readMode && byteCnt > 0) slvLow = 0;
      else begin
        logB[logN] = sh; logN++;
        slvLow = (byteCnt != nackAt);
        if (byteCnt == 0 && sh[0] && byteCnt != nackAt) readMode = 1;
      end
    end else if (bitCnt == 9) begin
      bitCnt = 0; byteCnt++; slvLow = 0;
      if (readMode && !masterNacked) begin
        tb = rdByte(byteCnt - 1);
        slvLow = ~tb[7];
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    logN = 0; mAckN = 0; starts = 0; stops = 0; nackAt = -1; badPeriod = 0; periods = 0;
  endtask

  // returns cycles from strobe release to the acknowledge pulse
  task automatic hostWrite(input logic [12:0] w, output int lat);
    @(negedge clk); hostWr = 1; hostWrData = w;
    @(negedge clk); hostWr = 0; hostWrData = '0;
    lat = 1;
    while (!hostAck && lat < 5000) begin @(negedge clk); lat++; end
  endtask

  task automatic hostRead(output logic [10:0] v, output int lat);
    @(negedge clk); hostRd = 1; #1 v = hostRdData;
    @(negedge clk); hostRd = 0;
    lat = 1;
    while (!hostAck && lat < 5000) begin @(negedge clk); lat++; end
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    #1;
    check("R1 status", hostRdData, 11'h100);
    check("R1 sclOe", sclOe, 0);
    check("R1 sdaOe", sdaOe, 0);
  endtask

  task automatic testQueueAndRead();
    logic [10:0] v; int lat;
    hostWrite(13'h211, lat);
    check("R5 ack latency plain write", lat, 1);
    hostWrite(13'h222, lat);
    hostWrite(13'h233, lat);
    hostRead(v, lat); check("R4 read head 1", v, 11'h011);
    check("R5 ack latency read", lat, 1);
    hostRead(v, lat); check("R4 read head 2", v, 11'h022);
    hostRead(v, lat); check("R4 read head 3", v, 11'h033);
    hostRead(v, lat); check("R4 read empty", v, 11'h100);
    hostRead(v, lat); check("R4 read empty stays", v, 11'h100);
  endtask

  task automatic testFull();
    logic [10:0] v; int lat;
    for (int i = 0; i < DEPTH + 1; i++) hostWrite(13'h200 | 13'(8'h40 + i), lat);
    #1 check("R2 full flag", hostRdData, 11'h240);
    for (int i = 0; i < DEPTH; i++) begin
      hostRead(v, lat);
      check("R2 drained order", v[7:0], 8'h40 + 8'(i));
    end
    #1 check("R2 extra append dropped", hostRdData, 11'h100);
  endtask

  task automatic testClear();
    int lat;
    hostWrite(13'h201, lat); hostWrite(13'h202, lat);
    hostWrite(13'h100, lat);
    #1 check("R3 clear empties", hostRdData, 11'h100);
    hostWrite(13'h3AA, lat);
    #1 check("R3 clear beats append", hostRdData, 11'h100);
  endtask

  task automatic testTransmit();
    int lat; logic [10:0] v;
    clearLog();
    hostWrite(13'h250, lat); hostWrite(13'h212, lat); hostWrite(13'h2C3, lat);
    hostWrite(13'h400, lat);
    check("R5 transaction ack delayed", lat > 100, 1);
    check("R6 byte count", logN, 3);
    check("R6 byte0", logB[0], 8'h50);
    check("R6 byte1", logB[1], 8'h12);
    check("R6 byte2", logB[2], 8'hC3);
    check("R12 single start", starts, 1);
    check("R12 single stop", stops, 1);
    check("R12 scl period", badPeriod, 0);
    check("R12 periods seen", periods > 20, 1);
    hostRead(v, lat); check("R6 queue empty after", v, 11'h100);
  endtask

  task automatic testTxEmpty();
    int lat;
    clearLog();
    hostWrite(13'h400, lat);
    check("R6 empty tx bytes", logN, 0);
    check("R6 empty tx start", starts, 1);
    check("R6 empty tx stop", stops, 1);
  endtask

  task automatic testTxNack();
    int lat; logic [10:0] v;
    clearLog(); nackAt = 1;
    hostWrite(13'h252, lat); hostWrite(13'h234, lat); hostWrite(13'h256, lat);
    hostWrite(13'h400, lat);
    check("R7 bytes sent before stop", logN, 2);
    check("R7 stop reached", stops, 1);
    hostRead(v, lat); check("R7 remaining byte and flag", v, 11'h456);
    clearLog();
    hostWrite(13'h252, lat); hostWrite(13'h400, lat);
    hostRead(v, lat); check("R11 flag cleared by new command", v, 11'h100);
  endtask

  task automatic testReceive();
    int lat; logic [10:0] v;
    clearLog();
    hostWrite(13'h1003, lat); hostWrite(13'h2A1, lat); hostWrite(13'h800, lat);
    check("R8 address sent", logB[0], 8'hA1);
    check("R8 only address written", logN, 1);
    check("R9 master ack count", mAckN, 3);
    check("R9 ack byte0", mAck[0], 1);
    check("R9 ack byte1", mAck[1], 1);
    check("R9 nack last", mAck[2], 0);
    for (int k = 0; k < 3; k++) begin
      hostRead(v, lat);
      check("R8 received byte", v, {3'b000, rdByte(k)});
    end
    #1 check("R8 queue empty after reads", hostRdData, 11'h100);
  endtask

  task automatic testReceiveZero();
    int lat;
    clearLog();
    hostWrite(13'h1000, lat); hostWrite(13'h2A1, lat); hostWrite(13'h800, lat);
    check("R9 zero count address only", logN, 1);
    check("R9 zero count no data", mAckN, 0);
    check("R9 zero count stop", stops, 1);
    #1 check("R9 zero count queue empty", hostRdData, 11'h100);
  endtask

  task automatic testReceiveAddrNack();
    int lat;
    clearLog(); nackAt = 0;
    hostWrite(13'h1002, lat); hostWrite(13'h2A1, lat); hostWrite(13'h800, lat);
    check("R10 no bytes read", mAckN, 0);
    #1 check("R10 flag set, queue empty", hostRdData, 11'h500);
  endtask

  task automatic testBusyIgnored();
    int lat; int acks = 0;
    clearLog();
    hostWrite(13'h250, lat);
    @(negedge clk); hostWr = 1; hostWrData = 13'h400;
    @(negedge clk); hostWr = 0;
    repeat (20) @(negedge clk);
    hostWr = 1; hostWrData = 13'h277;
    @(negedge clk); hostWr = 0; hostWrData = '0;
    if (hostAck) acks++;
    while (!hostAck) @(negedge clk);
    acks++;
    check("R5 single ack for busy period", acks, 1);
    check("R5 one byte sent", logN, 1);
    #1 check("R5 write while busy ignored", hostRdData, 11'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testQueueAndRead();
    testFull();
    testClear();
    testTransmit();
    testTxEmpty();
    testTxNack();
    testReceive();
    testReceiveZero();
    testReceiveAddrNack();
    testBusyIgnored();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule